// File: doc/BRIEF.md
# Debug TAP with Scan-Chain Selection

This block is the target side of a JTAG debug port for a processor debug unit. It contains the usual sixteen-state TAP controller, a 5-bit instruction register and a chain-select register. The chain-select register is written through a dedicated select instruction. The value it holds decides which internal chain the test-mode instructions reach. While the select instruction is active, the data path is the chain-select register itself. On capture it loads a fixed pattern, which lets the host confirm that the link is sound.

One chain is modelled in full: a 32-bit debug status/control register. The test-mode read instruction reads it and the test-mode write instruction writes it. A separate instruction reaches the instruction-transfer chain (chain 4) without altering the chain-select register. The block also emits a one-cycle execute strobe toward the instruction-transfer logic. The strobe fires when the controller enters Run-Test/Idle while chain 4 or 5 is the effective chain and a qualifying instruction is loaded. A host selects chain 0 to make later passes through Idle harmless.

Top module: `dbg_tap_chainsel`

## Requirements
- R1: With `trst_n` low at a rising `tck` edge, the controller goes to Test-Logic-Reset. The instruction becomes BYPASS (0x1F), the chain select becomes 0, the status register becomes 0, and `tdo` and `exec_strobe` are 0.
- R2: Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. Test-Logic-Reset restores BYPASS and chain 0.
- R3: The instruction register is 5 bits. It shifts LSB first and captures 0b00001 in Capture-IR. Codes: EXTEST-like write 0x00, chain select 0x02, INTEST-like read 0x0C, transfer select 0x1D, BYPASS 0x1F.
- R4: Under the chain-select instruction (0x02), the data path is the 5-bit chain-select register, and Capture-DR loads 0x10.
- R5: A newly shifted chain number shows on `chain_sel` only after the Update-DR state; during Shift-DR and Pause-DR the old value remains.
- R6: With chain 1 selected, read (0x0C) captures the 32-bit status register into the data path, and write (0x00) loads the shifted word into that register at Update-DR.
- R7: Under transfer select (0x1D), `chain_sel` reads 4 while the chain-select register keeps its value; loading another instruction shows the stored value again.
- R8: `exec_strobe` is high for exactly the first `tck` cycle in Run-Test/Idle when the effective chain is 4 or 5 and the instruction is 0x00, 0x0C or 0x1D; further Idle cycles give no pulse.
- R9: With chain 0 (or any chain other than 4 and 5) selected, or with any other instruction loaded, entering Idle gives no pulse.
- R10: `tdo` changes only on the falling edge of `tck`. It carries the register LSB in Shift-IR and Shift-DR and is 0 in all other states.
- R11: The write or read instruction with an unmodelled chain, BYPASS, and transfer select all use a 1-bit data path that captures 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset, sampled on rising `tck` |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| chain_sel | output | 5 | Effective chain number (4 under transfer select, otherwise the stored select) |
| exec_strobe | output | 1 | One-cycle execute request on qualifying Idle entry |

## Verification
Each serial result is due one falling edge after the rising edge that places the controller in a shift state. `chain_sel` changes one rising edge after Update-DR or Update-IR. The execute strobe rises with the rising edge that enters Idle. The bench advances a behavioural model of the controller at every rising edge. It compares `tdo`, `chain_sel` and `exec_strobe` with that model 1 ns after each falling edge, where all three are settled for the cycle. It rechecks `tdo` just after the next rising edge to show that `tdo` did not move there.

// File: rtl/dtap_pkg.sv
// Shared types and codes for the debug TAP.
// Assumes a 5-bit instruction register; chain widths are module parameters.
package dtap_pkg;

    localparam int IR_W = 5;

    typedef enum logic [3:0] {
        ST_TLR, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_WRITE   = 5'h00;
    localparam logic [IR_W-1:0] OP_CHSEL   = 5'h02;
    localparam logic [IR_W-1:0] OP_READ    = 5'h0C;
    localparam logic [IR_W-1:0] OP_XFERSEL = 5'h1D;
    localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;
    localparam logic [IR_W-1:0] IR_CAPVAL  = 5'b00001;

    typedef enum logic [1:0] {PATH_SEL, PATH_STAT, PATH_BYP} dr_path_t;

endpackage

// File: rtl/dtap_fsm.sv
// TAP controller state register and next-state decode.
// Assumes trst_n is synchronous to tck and active low.
module dtap_fsm
    import dtap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);
    tap_state_t nxt;
    logic [2:0] hi_run;

    // next-state decode per the standard TMS graph
    always_comb begin
        case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_TLR;
        endcase
    end

    // state register with synchronous test reset
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    // checker: run length of consecutive TMS-high edges, saturating at 4
    always_ff @(posedge tck) begin
        if (!trst_n)   hi_run <= 3'd0;
        else if (!tms) hi_run <= 3'd0;
        else if (hi_run != 3'd4) hi_run <= hi_run + 3'd1;
    end

    assert_trst_to_tlr_R1: assert property (@(posedge tck)
        !trst_n |=> state == ST_TLR);

    assert_five_high_tlr_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && hi_run == 3'd4) |=> state == ST_TLR);

endmodule

// File: rtl/dtap_ir.sv
// Instruction register: capture, serial shift (LSB first) and parallel update.
// Assumes the controller state comes from dtap_fsm on the same tck edge.
module dtap_ir
    import dtap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir,
    output logic            ir_lsb
);
    logic [IR_W-1:0] ir_sr;

    // shift stage: capture fixed value, then shift in from tdi
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sr <= IR_CAPVAL;
        else if (state == ST_CAP_IR) ir_sr <= IR_CAPVAL;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // active instruction: BYPASS on reset, load on Update-IR
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) ir <= OP_BYPASS;
        else if (state == ST_UPD_IR)     ir <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_CAP_IR |=> ir_sr == 5'b00001);

    assert_ir_stable_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir));

endmodule

// File: rtl/dtap_dr.sv
// Data-register side: chain-select register, status chain and 1-bit bypass.
// Assumes ir is stable through a DR scan (it only changes at Update-IR).
module dtap_dr
    import dtap_pkg::*;
#(
    parameter int SEL_W      = 5,
    parameter int STAT_W     = 32,
    parameter int STAT_CHAIN = 1,
    parameter int ITR_CHAIN  = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_t       state,
    input  logic [IR_W-1:0]  ir,
    input  logic             tdi,
    output logic [SEL_W-1:0] chain_sel,
    output logic             dr_lsb
);
    localparam logic [SEL_W-1:0] SEL_CHECK = SEL_W'(1) << (SEL_W - 1);
    localparam logic [SEL_W-1:0] STAT_ID   = SEL_W'(STAT_CHAIN);
    localparam logic [SEL_W-1:0] ITR_ID    = SEL_W'(ITR_CHAIN);

    logic [SEL_W-1:0]  screg, sel_sr;
    logic [STAT_W-1:0] stat_reg, stat_sr;
    logic              byp;
    dr_path_t          path;

    // pick the data path from the instruction and stored chain
    always_comb begin
        if (ir == OP_CHSEL)
            path = PATH_SEL;
        else if ((ir == OP_READ || ir == OP_WRITE) && screg == STAT_ID)
            path = PATH_STAT;
        else
            path = PATH_BYP;
    end

    // chain-select shift stage with link-check capture
    always_ff @(posedge tck) begin
        if (!trst_n)                                      sel_sr <= '0;
        else if (path == PATH_SEL && state == ST_CAP_DR)  sel_sr <= SEL_CHECK;
        else if (path == PATH_SEL && state == ST_SH_DR)   sel_sr <= {tdi, sel_sr[SEL_W-1:1]};
    end

    // stored chain number, changed only at Update-DR
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR)                   screg <= '0;
        else if (path == PATH_SEL && state == ST_UPD_DR)  screg <= sel_sr;
    end

    // status chain shift stage
    always_ff @(posedge tck) begin
        if (!trst_n)                                      stat_sr <= '0;
        else if (path == PATH_STAT && state == ST_CAP_DR) stat_sr <= stat_reg;
        else if (path == PATH_STAT && state == ST_SH_DR)  stat_sr <= {tdi, stat_sr[STAT_W-1:1]};
    end

    // status register, written by the write instruction at Update-DR
    always_ff @(posedge tck) begin
        if (!trst_n) stat_reg <= '0;
        else if (path == PATH_STAT && ir == OP_WRITE && state == ST_UPD_DR)
            stat_reg <= stat_sr;
    end

    // single-bit path for every unmodelled chain
    always_ff @(posedge tck) begin
        if (!trst_n)                                     byp <= 1'b0;
        else if (path == PATH_BYP && state == ST_CAP_DR) byp <= 1'b0;
        else if (path == PATH_BYP && state == ST_SH_DR)  byp <= tdi;
    end

    // serial output mux
    always_comb begin
        case (path)
            PATH_SEL:  dr_lsb = sel_sr[0];
            PATH_STAT: dr_lsb = stat_sr[0];
            default:   dr_lsb = byp;
        endcase
    end

    assign chain_sel = (ir == OP_XFERSEL) ? ITR_ID : screg;

    assert_sel_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && ir == OP_CHSEL) |=> sel_sr == SEL_CHECK);

    assert_screg_update_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_DR && state != ST_TLR) |=> $stable(screg));

    assert_stat_write_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (ir != OP_WRITE || state != ST_UPD_DR) |=> $stable(stat_reg));

endmodule

// File: rtl/dbg_tap_chainsel.sv
// Debug TAP top: controller, instruction register, chain paths,
// falling-edge TDO and the execute strobe on qualifying Idle entry.
// Assumes trst_n is synchronous to tck; TDO is driven 0 outside shift states.
module dbg_tap_chainsel
    import dtap_pkg::*;
#(
    parameter int SEL_W      = 5,
    parameter int STAT_W     = 32,
    parameter int STAT_CHAIN = 1,
    parameter int ITR_CHAIN  = 4,
    parameter int DTR_CHAIN  = 5
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic [SEL_W-1:0] chain_sel,
    output logic             exec_strobe
);
    tap_state_t      state;
    logic [IR_W-1:0] ir;
    logic            ir_lsb, dr_lsb, was_idle, exec_ok;

    dtap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

    dtap_ir u_ir (.tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
                  .ir(ir), .ir_lsb(ir_lsb));

    dtap_dr #(.SEL_W(SEL_W), .STAT_W(STAT_W), .STAT_CHAIN(STAT_CHAIN),
              .ITR_CHAIN(ITR_CHAIN))
        u_dr (.tck(tck), .trst_n(trst_n), .state(state), .ir(ir), .tdi(tdi),
              .chain_sel(chain_sel), .dr_lsb(dr_lsb));

    // remember whether the previous cycle was already in Idle
    always_ff @(posedge tck) begin
        if (!trst_n) was_idle <= 1'b0;
        else         was_idle <= (state == ST_IDLE);
    end

    // execution qualifier: transfer chains under an executing instruction
    always_comb begin
        exec_ok = (ir == OP_READ || ir == OP_WRITE || ir == OP_XFERSEL) &&
                  (chain_sel == SEL_W'(ITR_CHAIN) || chain_sel == SEL_W'(DTR_CHAIN));
    end

    assign exec_strobe = (state == ST_IDLE) && !was_idle && exec_ok;

    // serial output launched on the falling edge
    always_ff @(negedge tck) begin
        if (!trst_n)                tdo <= 1'b0;
        else if (state == ST_SH_IR) tdo <= ir_lsb;
        else if (state == ST_SH_DR) tdo <= dr_lsb;
        else                        tdo <= 1'b0;
    end

    assert_single_pulse_R8: assert property (@(posedge tck) disable iff (!trst_n)
        exec_strobe |=> !exec_strobe);

    assert_pulse_chain_R9: assert property (@(posedge tck) disable iff (!trst_n)
        exec_strobe |-> (chain_sel == SEL_W'(ITR_CHAIN) || chain_sel == SEL_W'(DTR_CHAIN)));

    assert_pulse_idle_R8: assert property (@(posedge tck) disable iff (!trst_n)
        exec_strobe |-> state == ST_IDLE);

endmodule

// File: tb/dbg_tap_chainsel_test.sv
`timescale 1ns/100ps
module dbg_tap_chainsel_test;
    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, exec_strobe;
    logic [4:0] chain_sel;
    int checks = 0, errors = 0, pulses = 0, cycles = 0;
    bit done = 0;

    dbg_tap_chainsel uut (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
                          .tdo(tdo), .chain_sel(chain_sel), .exec_strobe(exec_strobe));

    always #2 tck = ~tck;

    // behavioural reference: states as plain integers
    localparam int TLR=0, IDL=1, SDR=2, CDR=3, SHD=4, E1D=5, PD=6, E2D=7, UDR=8,
                   SIR=9, CIR=10, SHI=11, E1I=12, PI=13, E2I=14, UIR=15;
    int m_st = TLR, m_w = 1;
    logic [4:0] m_ir = 5'h1F, m_irsr = 5'h01, m_sel = 5'h00;
    logic [31:0] m_drsr = '0, m_stat = '0;
    bit m_was_idle = 0;

    function automatic int m_next(int s, logic t);
        case (s)
            TLR: return t ? TLR : IDL;  IDL: return t ? SDR : IDL;
            SDR: return t ? SIR : CDR;  CDR: return t ? E1D : SHD;
            SHD: return t ? E1D : SHD;  E1D: return t ? UDR : PD;
            PD:  return t ? E2D : PD;   E2D: return t ? UDR : SHD;
            UDR: return t ? SDR : IDL;  SIR: return t ? TLR : CIR;
            CIR: return t ? E1I : SHI;  SHI: return t ? E1I : SHI;
            E1I: return t ? UIR : PI;   PI:  return t ? E2I : PI;
            E2I: return t ? UIR : SHI;  default: return t ? SDR : IDL;
        endcase
    endfunction

    function automatic logic [4:0] m_chain();
        return (m_ir == 5'h1D) ? 5'd4 : m_sel;
    endfunction

    function automatic logic m_exec();
        return m_st == IDL && !m_was_idle &&
               (m_ir == 5'h00 || m_ir == 5'h0C || m_ir == 5'h1D) &&
               (m_chain() == 5'd4 || m_chain() == 5'd5);
    endfunction

    function automatic logic m_tdo();
        if (m_st == SHI) return m_irsr[0];
        if (m_st == SHD) return m_drsr[0];
        return 1'b0;
    endfunction

    task automatic m_edge(logic ms, logic mi, logic rn);
        if (!rn) begin
            m_st = TLR; m_ir = 5'h1F; m_sel = 0; m_stat = 0; m_was_idle = 0;
            return;
        end
        m_was_idle = (m_st == IDL);
        case (m_st)
            TLR: begin m_ir = 5'h1F; m_sel = 0; end
            CIR: m_irsr = 5'b00001;
            SHI: m_irsr = {mi, m_irsr[4:1]};
            UIR: m_ir = m_irsr;
            CDR: begin
                if (m_ir == 5'h02) begin m_drsr = 32'h10; m_w = 5; end
                else if ((m_ir == 5'h00 || m_ir == 5'h0C) && m_sel == 5'd1) begin
                    m_drsr = m_stat; m_w = 32;
                end else begin m_drsr = 0; m_w = 1; end
            end
            SHD: begin m_drsr = m_drsr >> 1; m_drsr[m_w-1] = mi; end
            UDR: begin
                if (m_ir == 5'h02) m_sel = m_drsr[4:0];
                else if (m_ir == 5'h00 && m_sel == 5'd1) m_stat = m_drsr;
            end
            default: ;
        endcase
        m_st = m_next(m_st, ms);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one tck cycle: compare with the model, drive, advance the model
    task automatic step(logic ms, logic mi, output logic obs);
        @(negedge tck); #1;
        chk("R10 tdo", {31'd0, tdo}, {31'd0, m_tdo()});
        chk("R5 chain_sel", {27'd0, chain_sel}, {27'd0, m_chain()});
        chk("R8 exec_strobe", {31'd0, exec_strobe}, {31'd0, m_exec()});
        obs = tdo;
        if (exec_strobe === 1'b1) pulses++;
        tms = ms; tdi = mi;
        @(posedge tck); #0.5;
        chk("R10 tdo held at rising edge", {31'd0, tdo}, {31'd0, obs});
        m_edge(ms, mi, trst_n);
    endtask

    task automatic idle(int n);
        logic b;
        for (int i = 0; i < n; i++) step(0, 0, b);
    endtask

    task automatic ir_scan(logic [4:0] code, output logic [4:0] cap);
        logic b;
        step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < 5; i++) begin step(i == 4, code[i], b); cap[i] = b; end
        step(1, 0, b); step(0, 0, b);
    endtask

    task automatic dr_scan(int w, logic [31:0] din, bit to_pause, output logic [31:0] dout);
        logic b;
        dout = '0;
        step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < w; i++) begin step(i == w - 1, din[i], b); dout[i] = b; end
        if (to_pause) begin step(0, 0, b); step(0, 0, b); end
        else begin step(1, 0, b); step(0, 0, b); end
    endtask

    task automatic leave_pause();
        logic b;
        step(1, 0, b); step(1, 0, b); step(0, 0, b);
    endtask

    always @(posedge tck) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog actual %0d expected <100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] c5;
        logic [31:0] d;
        logic b;
        step(1, 0, b); step(1, 0, b); step(1, 0, b);
        chk("R1 chain after reset", {27'd0, chain_sel}, 32'd0);
        chk("R1 tdo after reset", {31'd0, tdo}, 32'd0);
        trst_n = 1'b1;
        step(0, 0, b);
        idle(2);

        // R3: IR capture shifts out 00001
        ir_scan(5'h02, c5);
        chk("R3 ir capture", {27'd0, c5}, 32'h01);
        // R4: link-check capture, R5: chain 1 after update
        dr_scan(5, 32'd1, 0, d);
        chk("R4 select capture", d, 32'h10);
        chk("R5 chain after update", {27'd0, chain_sel}, 32'd1);

        // R6: write then read the status chain
        ir_scan(5'h00, c5);
        dr_scan(32, 32'hA5C3_1E0F, 0, d);
        chk("R6 old status", d, 32'h0);
        ir_scan(5'h0C, c5);
        dr_scan(32, 32'h0, 0, d);
        chk("R6 status readback", d, 32'hA5C3_1E0F);

        // R5: new chain not visible in Pause-DR
        ir_scan(5'h02, c5);
        pulses = 0;
        dr_scan(5, 32'd5, 1, d);
        chk("R5 chain held in pause", {27'd0, chain_sel}, 32'd1);
        leave_pause();
        idle(3);
        chk("R5 chain after update", {27'd0, chain_sel}, 32'd5);
        chk("R9 no pulse under select instr", pulses, 32'd0);

        // R8: one pulse on Idle entry with chain 5 and read
        pulses = 0;
        ir_scan(5'h0C, c5);
        idle(6);
        chk("R8 one pulse chain 5", pulses, 32'd1);

        // R7: transfer select shows chain 4 and pulses; stored chain kept
        pulses = 0;
        ir_scan(5'h1D, c5);
        idle(2);
        chk("R7 chain under xfer", {27'd0, chain_sel}, 32'd4);
        chk("R8 pulse under xfer", pulses, 32'd1);
        ir_scan(5'h00, c5);
        idle(2);
        chk("R7 stored chain back", {27'd0, chain_sel}, 32'd5);
        chk("R8 pulse under write", pulses, 32'd2);

        // R9: chain 0 makes Idle harmless
        ir_scan(5'h02, c5);
        dr_scan(5, 32'd0, 0, d);
        pulses = 0;
        ir_scan(5'h0C, c5);
        idle(5);
        chk("R9 no pulse chain 0", pulses, 32'd0);
        chk("R10 tdo zero in idle", {31'd0, tdo}, 32'd0);

        // R11: unmodelled chain is one bit capturing 0
        ir_scan(5'h02, c5);
        dr_scan(5, 32'd7, 0, d);
        ir_scan(5'h00, c5);
        dr_scan(3, 32'b101, 0, d);
        chk("R11 one-bit path", d, 32'b010);

        // R2: five TMS-high edges from Shift-DR
        step(1, 0, b); step(0, 0, b); step(0, 0, b);
        for (int i = 0; i < 5; i++) step(1, 0, b);
        step(0, 0, b);
        chk("R2 chain after tms reset", {27'd0, chain_sel}, 32'd0);
        dr_scan(2, 32'b11, 0, d);
        chk("R2 bypass after tms reset", d, 32'b10);

        // R1: test reset mid-run clears the chain select
        ir_scan(5'h02, c5);
        dr_scan(5, 32'd5, 0, d);
        trst_n = 1'b0;
        step(0, 0, b); step(0, 0, b);
        trst_n = 1'b1;
        step(0, 0, b);
        chk("R1 chain after trst", {27'd0, chain_sel}, 32'd0);
        idle(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule